// File: doc/BRIEF.md
# Cross-Stream Branch Outcome Link with Deadlock Watch

Two decoupled instruction streams, an access stream and an execute stream, each follow the same program's control flow. When one stream settles a conditional branch from its own data, it sends the single taken/not-taken bit to the other stream over a dedicated one-bit FIFO. The other stream meets the matching branch as a branch-from-queue operation and takes its direction from the oldest bit waiting in its incoming FIFO, consuming that bit. So every conditional branch appears as a producer/consumer pair, one half in each stream. There is one FIFO for each direction.

A stream that wants to send an outcome while its outgoing FIFO is full, or to consume an outcome while its incoming FIFO is empty, stalls. Each stream also reports whether it is stalled on one of its data queues. A watch circuit raises a sticky deadlock flag once both streams have been stalled on queue conditions for a set number of consecutive cycles. Surrounding logic treats the flag as a program error and purges the program.

Top module: `branch_link`

## Requirements
- R1: After reset both FIFOs are empty: `a_res_ready` and `e_res_ready` are 1, `a_bfq_ready` and `e_bfq_ready` are 0, and `deadlock` is 0.
- R2: Outcome bits sent by one stream (a clock edge with `*_res_valid`=1 and `*_res_ready`=1) are presented to the other stream on `*_bfq_taken`, where 1 means taken, in the order they were sent, one bit removed per edge with `*_bfq_valid`=1 and `*_bfq_ready`=1.
- R3: With DEPTH bits stored, the sending side sees `*_res_ready`=0, and a send attempted then stores nothing: draining afterwards yields exactly the DEPTH stored bits.
- R4: With an empty FIFO the receiving side sees `*_bfq_ready`=0, and a consume attempted then removes nothing: a later send is still delivered.
- R5: The access-to-execute FIFO and the execute-to-access FIFO are independent; traffic in one leaves the other's status unchanged.
- R6: A send and a consume on the same edge to a FIFO that is neither full nor empty keep its fill level and preserve order.
- R7: A stream is stalled when its data-queue stall input is 1, or it requests a send with a full outgoing FIFO, or it requests a consume with an empty incoming FIFO. `deadlock` goes to 1 after the edge that completes HOLD consecutive edges on which both streams are stalled.
- R8: If both-stalled holds for fewer than HOLD consecutive edges and is then broken, `deadlock` stays 0 and the count starts over.
- R9: Once set, `deadlock` stays 1 until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_res_valid | input | 1 | Access stream sends a resolved outcome |
| a_res_taken | input | 1 | Outcome sent by access stream, 1 = taken |
| a_res_ready | output | 1 | Access-to-execute FIFO can accept a bit |
| a_bfq_valid | input | 1 | Access stream executes branch-from-queue |
| a_bfq_ready | output | 1 | Execute-to-access FIFO holds a bit |
| a_bfq_taken | output | 1 | Oldest bit of execute-to-access FIFO |
| a_data_stall | input | 1 | Access stream stalled on a data queue |
| e_res_valid | input | 1 | Execute stream sends a resolved outcome |
| e_res_taken | input | 1 | Outcome sent by execute stream, 1 = taken |
| e_res_ready | output | 1 | Execute-to-access FIFO can accept a bit |
| e_bfq_valid | input | 1 | Execute stream executes branch-from-queue |
| e_bfq_ready | output | 1 | Access-to-execute FIFO holds a bit |
| e_bfq_taken | output | 1 | Oldest bit of access-to-execute FIFO |
| e_data_stall | input | 1 | Execute stream stalled on a data queue |
| deadlock | output | 1 | Sticky mutual-stall error flag |

## Verification
The hardest condition to reach is a deadlock built from mixed causes that persists for exactly HOLD edges, and one that falls one edge short. The stimulus parks the execute stream on a consume from an empty FIFO while the access stream raises its data-stall input, holds that for HOLD-1 edges, breaks it for one edge to show the count restarts, then holds it again and samples the flag on both sides of the completing edge. The full and empty boundaries are reached by filling a FIFO to DEPTH and attempting one more send, then draining and checking that exactly the stored bits come out.

// File: rtl/brq_pkg.sv
package brq_pkg;
  // Circular pointer advance for a buffer of `depth` slots.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Stall reasons of one stream folded into one bit.
  function automatic logic stream_stalled(input logic data_stall,
                                          input logic send_req, input logic out_full,
                                          input logic take_req, input logic in_empty);
    return data_stall | (send_req & out_full) | (take_req & in_empty);
  endfunction
endpackage

// File: rtl/outcome_fifo.sv
module outcome_fifo #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic push_bit,
  input  logic pop,
  output logic full,
  output logic empty,
  output logic head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] slots;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill;
  logic             push_acc, pop_acc;

  assign full     = (fill == CW'(DEPTH));
  assign empty    = (fill == '0);
  assign head     = slots[rd_ptr];
  assign push_acc = push & ~full;
  assign pop_acc  = pop & ~empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
      slots  <= '0;
    end else begin
      if (push_acc) begin
        slots[wr_ptr] <= push_bit;
        wr_ptr <= AW'(brq_pkg::wrap_inc(32'(wr_ptr), DEPTH));
      end
      if (pop_acc)
        rd_ptr <= AW'(brq_pkg::wrap_inc(32'(rd_ptr), DEPTH));
      if (push_acc && !pop_acc)
        fill <= fill + 1'b1;
      else if (pop_acc && !push_acc)
        fill <= fill - 1'b1;
    end
  end

  // R3: a full FIFO stays full unless a bit leaves
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);
  // R4: an empty FIFO stays empty unless a bit enters
  a_r4_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
  // R6: same-edge send and consume keep the fill level
  a_r6_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> $stable(fill));
endmodule

// File: rtl/deadlock_watch.sv
module deadlock_watch #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_stuck,
  input  logic e_stuck,
  output logic flag
);
  localparam int RW = (HOLD > 1) ? $clog2(HOLD) : 1;

  logic          both;
  logic [RW-1:0] run;

  assign both = a_stuck & e_stuck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= '0;
      flag <= 1'b0;
    end else begin
      if (!both)
        run <= '0;
      else if (run != RW'(HOLD - 1))
        run <= run + 1'b1;
      if (both && run == RW'(HOLD - 1))
        flag <= 1'b1;
    end
  end

  // R7: the flag only rises on an edge where both streams were stalled
  a_r7_rise_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(both));
  // R9: once raised the flag never drops before reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag);
endmodule

// File: rtl/branch_link.sv
module branch_link #(
  parameter int DEPTH = 4,
  parameter int HOLD  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_res_valid,
  input  logic a_res_taken,
  output logic a_res_ready,
  input  logic a_bfq_valid,
  output logic a_bfq_ready,
  output logic a_bfq_taken,
  input  logic a_data_stall,
  input  logic e_res_valid,
  input  logic e_res_taken,
  output logic e_res_ready,
  input  logic e_bfq_valid,
  output logic e_bfq_ready,
  output logic e_bfq_taken,
  input  logic e_data_stall,
  output logic deadlock
);
  logic ae_full, ae_empty, ea_full, ea_empty;
  logic a_stuck, e_stuck;

  // access -> execute outcomes
  outcome_fifo #(.DEPTH(DEPTH)) u_ae (
    .clk(clk), .rst_n(rst_n),
    .push(a_res_valid), .push_bit(a_res_taken), .pop(e_bfq_valid),
    .full(ae_full), .empty(ae_empty), .head(e_bfq_taken));

  // execute -> access outcomes
  outcome_fifo #(.DEPTH(DEPTH)) u_ea (
    .clk(clk), .rst_n(rst_n),
    .push(e_res_valid), .push_bit(e_res_taken), .pop(a_bfq_valid),
    .full(ea_full), .empty(ea_empty), .head(a_bfq_taken));

  assign a_res_ready = ~ae_full;
  assign e_res_ready = ~ea_full;
  assign a_bfq_ready = ~ea_empty;
  assign e_bfq_ready = ~ae_empty;

  assign a_stuck = brq_pkg::stream_stalled(a_data_stall, a_res_valid, ae_full,
                                           a_bfq_valid, ea_empty);
  assign e_stuck = brq_pkg::stream_stalled(e_data_stall, e_res_valid, ea_full,
                                           e_bfq_valid, ae_empty);

  deadlock_watch #(.HOLD(HOLD)) u_watch (
    .clk(clk), .rst_n(rst_n), .a_stuck(a_stuck), .e_stuck(e_stuck), .flag(deadlock));

  // R5: sending toward execute never changes what the access side sees
  a_r5_ea_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (a_res_valid && !e_res_valid && !a_bfq_valid) |=> $stable(a_bfq_ready));
endmodule

// File: tb/tb_branch_link.sv
module tb_branch_link;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int HOLD  = 8;

  logic clk = 0, rst_n = 0;
  logic a_res_valid = 0, a_res_taken = 0, a_bfq_valid = 0, a_data_stall = 0;
  logic e_res_valid = 0, e_res_taken = 0, e_bfq_valid = 0, e_data_stall = 0;
  logic a_res_ready, a_bfq_ready, a_bfq_taken, e_res_ready, e_bfq_ready, e_bfq_taken, deadlock;

  int checks = 0, fails = 0;
  bit done = 0;
  bit exp_ae[$];
  bit exp_ea[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_link #(.DEPTH(DEPTH), .HOLD(HOLD)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compares each consumed outcome with the scoreboard (R2)
  always @(negedge clk) begin
    if (rst_n && e_bfq_valid && e_bfq_ready) begin
      if (exp_ae.size() == 0) check("R2 a->e unexpected bit", 1, 0);
      else check("R2 a->e order", e_bfq_taken, exp_ae.pop_front());
    end
    if (rst_n && a_bfq_valid && a_bfq_ready) begin
      if (exp_ea.size() == 0) check("R2 e->a unexpected bit", 1, 0);
      else check("R2 e->a order", a_bfq_taken, exp_ea.pop_front());
    end
  end

  task automatic do_reset();
    rst_n = 0;
    exp_ae.delete(); exp_ea.delete();
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic a_send(bit b);
    a_res_valid = 1; a_res_taken = b;
    @(negedge clk);
    if (a_res_ready) exp_ae.push_back(b);
    @(posedge clk); #1 a_res_valid = 0;
  endtask

  task automatic e_send(bit b);
    e_res_valid = 1; e_res_taken = b;
    @(negedge clk);
    if (e_res_ready) exp_ea.push_back(b);
    @(posedge clk); #1 e_res_valid = 0;
  endtask

  task automatic e_take();
    e_bfq_valid = 1;
    @(posedge clk); #1 e_bfq_valid = 0;
  endtask

  task automatic a_take();
    a_bfq_valid = 1;
    @(posedge clk); #1 a_bfq_valid = 0;
  endtask

  task automatic ae_both(bit b);
    a_res_valid = 1; a_res_taken = b; e_bfq_valid = 1;
    @(negedge clk);
    if (a_res_ready) exp_ae.push_back(b);
    @(posedge clk); #1 a_res_valid = 0; e_bfq_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 a_res_ready", a_res_ready, 1);
    check("R1 e_res_ready", e_res_ready, 1);
    check("R1 a_bfq_ready", a_bfq_ready, 0);
    check("R1 e_bfq_ready", e_bfq_ready, 0);
    check("R1 deadlock", deadlock, 0);
    @(posedge clk); #1;

    // R2 ordered delivery a->e
    a_send(1); a_send(0); a_send(1);
    repeat (3) e_take();
    @(negedge clk);
    check("R2 drained", e_bfq_ready, 0);
    check("R2 scoreboard empty", exp_ae.size(), 0);
    @(posedge clk); #1;

    // R3 full boundary, extra send ignored
    a_send(1); a_send(1); a_send(0); a_send(1);
    @(negedge clk);
    check("R3 full ready low", a_res_ready, 0);
    @(posedge clk); #1;
    a_send(0);
    repeat (DEPTH) e_take();
    @(negedge clk);
    check("R3 no extra bit stored", e_bfq_ready, 0);
    check("R3 scoreboard empty", exp_ae.size(), 0);
    @(posedge clk); #1;

    // R4 consume from empty ignored
    e_take(); e_take();
    a_send(0);
    @(negedge clk);
    check("R4 bit still delivered", e_bfq_ready, 1);
    check("R4 head value", e_bfq_taken, 0);
    @(posedge clk); #1;
    e_take();

    // R5 independence of directions
    e_send(0); e_send(1);
    @(negedge clk);
    check("R5 a->e unaffected", e_bfq_ready, 0);
    check("R5 a_res_ready unaffected", a_res_ready, 1);
    check("R5 e->a has bits", a_bfq_ready, 1);
    @(posedge clk); #1;
    a_take(); a_take();

    // R6 same-edge send and consume
    a_send(1); a_send(0);
    ae_both(1); ae_both(1); ae_both(0);
    @(negedge clk);
    check("R6 level kept", exp_ae.size(), 2);
    check("R6 not full", a_res_ready, 1);
    @(posedge clk); #1;
    e_take(); e_take();
    @(negedge clk);
    check("R6 drained", e_bfq_ready, 0);
    @(posedge clk); #1;

    // R8 short mutual stall then break; R7 mixed-cause stall
    e_bfq_valid = 1; a_data_stall = 1;
    repeat (HOLD - 1) @(posedge clk);
    @(negedge clk);
    check("R8 short stall no flag", deadlock, 0);
    a_data_stall = 0;
    @(posedge clk); #1;
    a_data_stall = 1;
    repeat (HOLD - 1) @(posedge clk);
    @(negedge clk);
    check("R7 one edge short", deadlock, 0);
    @(posedge clk);
    @(negedge clk);
    check("R7 flag after HOLD edges", deadlock, 1);
    e_bfq_valid = 0; a_data_stall = 0;

    // R9 sticky
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R9 sticky", deadlock, 1);
    do_reset();
    @(negedge clk);
    check("R9 cleared by reset", deadlock, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule